// File: doc/BRIEF.md
# Relative Branch Next-Address Unit

This block works out where the program counter goes after a branch instruction, for a processor whose instructions are all one 16-bit word long. A decode stage gives it the address of the branch, the offset field from the instruction word, a bit that marks the branch as unconditional, a four-bit condition selector and the current arithmetic flags. One clock later it returns the address of the next instruction to fetch and a bit that says whether the branch was taken.

The offset counts words, not bytes, and counts from the instruction after the branch. A conditional branch uses the low nine bits of the offset field as a signed word count. The unconditional form uses all ten bits. The unit sign-extends the selected field and doubles it to a byte distance. It then adds that distance to the branch address plus two. A branch that is not taken falls through to the branch address plus two. All address arithmetic wraps at the width of the program counter, and bit 0 of every address is treated as zero.

Instruction fetch, pipeline flushing and the flag register itself belong to other blocks.

Top module: `bt_next_pc`

## Requirements
- R1: While `rst_n` is low, `next_pc_o` is 0 and `taken_o` is 0.
- R2: The inputs present at a rising clock edge decide `next_pc_o` and `taken_o` from that edge until the next one, which is a latency of one cycle.
- R3: When the branch is not taken, `next_pc_o` equals the branch address plus 2.
- R4: A taken conditional branch goes to the branch address + 2 + 2 × sext(`ofs_i[8:0]`). This reaches from +255 to −256 words, and `ofs_i[9]` has no effect on a conditional branch.
- R5: When `uncond_i` is 1, the branch is always taken to the branch address + 2 + 2 × sext(`ofs_i[9:0]`). This reaches from +511 to −512 words, and `cond_i` and `flags_i` have no effect.
- R6: `flags_i` is {N, Z, V, C}, with N in bit 3 and C in bit 0. Condition code 0 (equal) is taken when Z = 1, and code 1 (not equal) is taken when Z = 0.
- R7: The single-flag codes are as follows: 2 is taken when C = 1, 3 when C = 0, 4 when N = 1, 5 when N = 0, 6 when V = 1 and 7 when V = 0.
- R8: The signed codes are as follows: 8 is taken when N xor V = 0, 9 when N xor V = 1, 10 when Z = 0 and N xor V = 0, and 11 when Z = 1 or N xor V = 1.
- R9: Condition codes 12 to 15 never take a conditional branch.
- R10: `pc_i[0]` is ignored, and `next_pc_o[0]` is always 0.
- R11: All address sums wrap modulo 2^16. For example, a branch address of 0xFFFE falls through to 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the outputs update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 16 | Address of the branch instruction |
| ofs_i | input | 10 | Signed word offset field of the instruction |
| uncond_i | input | 1 | 1 for an unconditional branch, 0 for a conditional branch |
| cond_i | input | 4 | Condition selector; the codes are listed in R6 to R9 |
| flags_i | input | 4 | Current flags {N, Z, V, C} |
| next_pc_o | output | 16 | Address of the next instruction to fetch |
| taken_o | output | 1 | 1 when the branch was taken |

## Verification
The unit holds state only in its output register, so a wrong stored value shows at the ports one cycle after the edge that captured it. The next vector overwrites it one cycle later, so it is never visible for longer than that. A wrong condition decode shows as a wrong `taken_o` and, at the same time, a fall-through address where a target was expected, or the reverse. Faults in offset width or sign extension show only near the reach limits and at wrap-around. For that reason the vectors include the largest forward and backward offsets of both branch forms, address 0xFFFE, and every pair of condition code and flag value.

// File: rtl/bt_pkg.sv
package bt_pkg;

   // Flag bit positions inside the {N,Z,V,C} flag vector
   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_V = 1;
   localparam int FLG_C = 0;
   localparam int FLG_W = 4;
   localparam int CC_W  = 4;

   typedef enum logic [CC_W-1:0] {
      CC_EQ = 4'd0,  CC_NE = 4'd1,
      CC_CS = 4'd2,  CC_CC = 4'd3,
      CC_MI = 4'd4,  CC_PL = 4'd5,
      CC_VS = 4'd6,  CC_VC = 4'd7,
      CC_GE = 4'd8,  CC_LT = 4'd9,
      CC_GT = 4'd10, CC_LE = 4'd11
   } cc_e;

endpackage

// File: rtl/bt_ofs_scale.sv
// Sign-extends a signed word offset and converts it to a byte distance.
module bt_ofs_scale #(
   parameter int IN_W  = 9,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  ofs_i,
   output logic [OUT_W-1:0] byte_ofs_o
);
   localparam int EXT_W = OUT_W - IN_W - 1;

   generate
      if (IN_W < 2) begin : g_bad_in
         $error("bt_ofs_scale: IN_W must be at least 2");
      end
      if (EXT_W < 0) begin : g_bad_out
         $error("bt_ofs_scale: OUT_W too narrow for scaled offset");
      end else if (EXT_W == 0) begin : g_fit
         assign byte_ofs_o = {ofs_i, 1'b0};
      end else begin : g_ext
         assign byte_ofs_o = {{EXT_W{ofs_i[IN_W-1]}}, ofs_i, 1'b0};
      end
   endgenerate
endmodule

// File: rtl/bt_cond_eval.sv
// Decides whether a conditional branch is taken, from the selector and the flags.
module bt_cond_eval
   import bt_pkg::*;
(
   input  logic [CC_W-1:0]  cond_i,
   input  logic [FLG_W-1:0] flags_i,
   output logic             pass_o
);
   logic n_f, z_f, v_f, c_f, lt_f;

   assign n_f  = flags_i[FLG_N];
   assign z_f  = flags_i[FLG_Z];
   assign v_f  = flags_i[FLG_V];
   assign c_f  = flags_i[FLG_C];
   assign lt_f = n_f ^ v_f;

   always_comb begin
      case (cond_i)
         CC_EQ:   pass_o = z_f;
         CC_NE:   pass_o = ~z_f;
         CC_CS:   pass_o = c_f;
         CC_CC:   pass_o = ~c_f;
         CC_MI:   pass_o = n_f;
         CC_PL:   pass_o = ~n_f;
         CC_VS:   pass_o = v_f;
         CC_VC:   pass_o = ~v_f;
         CC_GE:   pass_o = ~lt_f;
         CC_LT:   pass_o = lt_f;
         CC_GT:   pass_o = ~z_f & ~lt_f;
         CC_LE:   pass_o = z_f | lt_f;
         default: pass_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/bt_pc_add.sv
// Adds the instruction size to the aligned address, then adds the offset when the branch is taken.
module bt_pc_add #(
   parameter int PC_W     = 16,
   parameter int STEP_B   = 2
) (
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] ofs_i,
   input  logic            take_i,
   output logic [PC_W-1:0] next_o
);
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] tgt_pc;

   assign seq_pc = pc_i + PC_W'(STEP_B);
   assign tgt_pc = seq_pc + ofs_i;
   assign next_o = take_i ? tgt_pc : seq_pc;
endmodule

// File: rtl/bt_next_pc.sv
module bt_next_pc
   import bt_pkg::*;
#(
   parameter int PC_W       = 16,
   parameter int COND_OFS_W = 9,
   parameter int JUMP_OFS_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PC_W-1:0]       pc_i,
   input  logic [JUMP_OFS_W-1:0] ofs_i,
   input  logic                  uncond_i,
   input  logic [CC_W-1:0]       cond_i,
   input  logic [FLG_W-1:0]      flags_i,
   output logic [PC_W-1:0]       next_pc_o,
   output logic                  taken_o
);
   localparam int STEP_B = 2;
   localparam logic [PC_W-1:0] ALIGN_MASK = {{(PC_W-1){1'b1}}, 1'b0};
   localparam int COND_FWD = 2 * ((2 ** (COND_OFS_W-1)) - 1);
   localparam int COND_BWD = -2 * (2 ** (COND_OFS_W-1));

   generate
      if (COND_OFS_W >= JUMP_OFS_W) begin : g_bad_w
         $error("bt_next_pc: conditional offset must be narrower than jump offset");
      end
      if (JUMP_OFS_W + 1 > PC_W) begin : g_bad_pc
         $error("bt_next_pc: PC_W too narrow for jump reach");
      end
   endgenerate

   logic [PC_W-1:0] pc_al;
   logic [PC_W-1:0] c_ofs, j_ofs, sel_ofs, nxt_d;
   logic            cond_ok, take_d;

   assign pc_al = pc_i & ALIGN_MASK;

   bt_ofs_scale #(.IN_W(COND_OFS_W), .OUT_W(PC_W)) u_cofs (
      .ofs_i      (ofs_i[COND_OFS_W-1:0]),
      .byte_ofs_o (c_ofs)
   );

   bt_ofs_scale #(.IN_W(JUMP_OFS_W), .OUT_W(PC_W)) u_jofs (
      .ofs_i      (ofs_i),
      .byte_ofs_o (j_ofs)
   );

   bt_cond_eval u_cond (
      .cond_i  (cond_i),
      .flags_i (flags_i),
      .pass_o  (cond_ok)
   );

   assign sel_ofs = uncond_i ? j_ofs : c_ofs;
   assign take_d  = uncond_i | cond_ok;

   bt_pc_add #(.PC_W(PC_W), .STEP_B(STEP_B)) u_add (
      .pc_i   (pc_al),
      .ofs_i  (sel_ofs),
      .take_i (take_d),
      .next_o (nxt_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc_o <= '0;
         taken_o   <= 1'b0;
      end else begin
         next_pc_o <= nxt_d;
         taken_o   <= take_d;
      end
   end

   // Marks that the output register holds a value computed after reset
   logic seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   // R3
   fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && !taken_o) |-> (next_pc_o == ($past(pc_al) + PC_W'(STEP_B))));

   // R5
   uncond_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(uncond_i)) |-> taken_o);

   // R9
   rsvd_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && $past(!uncond_i && (cond_i >= CC_W'(12)))) |-> !taken_o);

   // R4
   cond_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && taken_o && !$past(uncond_i)) |->
      (($signed(next_pc_o - ($past(pc_al) + PC_W'(STEP_B))) <= COND_FWD) &&
       ($signed(next_pc_o - ($past(pc_al) + PC_W'(STEP_B))) >= COND_BWD)));

   // R10
   even_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (next_pc_o[0] == 1'b0));
endmodule

// File: tb/sim_bt_next_pc.sv
`timescale 1ns/1ps
module sim_bt_next_pc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc_i = '0;
   logic [9:0]  ofs_i = '0;
   logic        uncond_i = 1'b0;
   logic [3:0]  cond_i = '0;
   logic [3:0]  flags_i = '0;
   logic [15:0] next_pc_o;
   logic        taken_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   typedef struct {
      logic [15:0] pc;
      logic        tk;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   bt_next_pc u0 (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ofs_i(ofs_i),
      .uncond_i(uncond_i), .cond_i(cond_i), .flags_i(flags_i),
      .next_pc_o(next_pc_o), .taken_o(taken_o)
   );

   // Condition decision taken from the requirement text; flags are {N,Z,V,C}
   function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f);
      logic n, z, v, c, x;
      n = f[3]; z = f[2]; v = f[1]; c = f[0]; x = n ^ v;
      case (cc)
         4'd0:  return z;          // R6
         4'd1:  return !z;         // R6
         4'd2:  return c;          // R7
         4'd3:  return !c;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return !x;         // R8
         4'd9:  return x;
         4'd10: return !z && !x;
         4'd11: return z || x;
         default: return 1'b0;     // R9
      endcase
   endfunction

   task automatic apply(input logic [15:0] pc, input logic [9:0] ofs,
                        input logic unc, input logic [3:0] cc,
                        input logic [3:0] fl, input string tag);
      exp_t e;
      int   o;
      int   base;
      @(negedge clk);
      pc_i = pc; ofs_i = ofs; uncond_i = unc; cond_i = cc; flags_i = fl;
      base = int'({pc[15:1], 1'b0}) + 2;
      o    = unc ? int'($signed(ofs)) : int'($signed(ofs[8:0]));
      e.tk = unc ? 1'b1 : ref_pass(cc, fl);
      e.pc = e.tk ? 16'(base + 2 * o) : 16'(base);
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: each output appears at the rising edge that follows the drive
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         n_vec++;
         if (next_pc_o !== e.pc || taken_o !== e.tk) begin
            n_bad++;
            $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
                     e.tag, next_pc_o, taken_o, e.pc, e.tk);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      pc_i = 16'h4444; ofs_i = 10'h155; uncond_i = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if (next_pc_o !== 16'h0000 || taken_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: next_pc=%h taken=%b expected next_pc=0000 taken=0",
                  next_pc_o, taken_o);
      end
      rst_n = 1'b1;

      apply(16'h0100, 10'h004, 1'b0, 4'd0, 4'b0100, "R2 one-cycle result EQ taken");
      apply(16'h0100, 10'h004, 1'b0, 4'd0, 4'b0000, "R6 EQ Z=0 falls through");
      apply(16'h0100, 10'h004, 1'b0, 4'd1, 4'b0000, "R6 NE Z=0 taken");
      apply(16'h0200, 10'h010, 1'b0, 4'd2, 4'b0000, "R3 CS not taken");
      apply(16'h1000, 10'h0FF, 1'b0, 4'd0, 4'b0100, "R4 cond max forward");
      apply(16'h1000, 10'h100, 1'b0, 4'd0, 4'b0100, "R4 cond max backward");
      apply(16'h1000, 10'h2FF, 1'b0, 4'd0, 4'b0100, "R4 ofs bit9 ignored on cond");
      apply(16'h2000, 10'h1FF, 1'b1, 4'd0, 4'b0000, "R5 jump max forward");
      apply(16'h2000, 10'h200, 1'b1, 4'd0, 4'b0000, "R5 jump max backward");
      apply(16'h2000, 10'h003, 1'b1, 4'd13, 4'b1111, "R5 cond and flags ignored");
      apply(16'h3000, 10'h020, 1'b0, 4'd12, 4'b1111, "R9 code 12 not taken");
      apply(16'h3000, 10'h020, 1'b0, 4'd15, 4'b0000, "R9 code 15 not taken");
      apply(16'h1235, 10'h000, 1'b0, 4'd14, 4'b0000, "R10 odd pc falls through");
      apply(16'h1235, 10'h002, 1'b1, 4'd0, 4'b0000, "R10 odd pc jump");
      apply(16'hFFFE, 10'h000, 1'b0, 4'd1, 4'b0100, "R11 fall-through wraps");
      apply(16'hFFFE, 10'h001, 1'b1, 4'd0, 4'b0000, "R11 forward jump wraps");
      apply(16'h0000, 10'h200, 1'b1, 4'd0, 4'b0000, "R11 backward jump wraps");
      apply(16'h0000, 10'h100, 1'b0, 4'd8, 4'b0000, "R11 backward cond wraps");

      // R6 R7 R8 R9: every condition code against every flag value
      for (int cc = 0; cc < 16; cc++) begin
         for (int fl = 0; fl < 16; fl++) begin
            apply(16'h5000 + 16'(cc * 64), 10'h0F0, 1'b0, 4'(cc), 4'(fl),
                  "R6 R7 R8 R9 condition sweep");
         end
      end

      // R3 R4 R5 R10 R11: random vectors
      for (int k = 0; k < 400; k++) begin
         apply(16'($urandom), 10'($urandom), 1'($urandom), 4'($urandom),
               4'($urandom), "R4 R5 random");
      end

      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule